// File: doc/BRIEF.md
# Multi-Channel Mailbox State Controller

This block keeps the handshake state of a set of single-entry mailboxes that link a host to an I/O processor. Each of the seven channels has two slots. In the send slot the host posts a message and the processor answers. In the receive slot the processor posts and the host answers. The message bytes themselves live in a separate RAM. This block holds only the two-bit state of every slot. It accepts a state change from a side only when the slot's handshake permits that change for that side.

Every slot walks the same cycle: IDLE, then NEW, then RCVD, then COMPLETE, then back to IDLE. The side that starts the exchange is the owner. The owner is the host for send slots and the processor for receive slots. The owner makes the moves IDLE to NEW (post) and COMPLETE to IDLE (retire). The other side is the responder. It makes the moves NEW to RCVD (accept) and RCVD to COMPLETE (finish). Any other request is dropped and raises a sticky protocol error.

Two sticky interrupt flags collect the channel events. The send flag fires when any send slot enters COMPLETE. The receive flag fires when any receive slot enters NEW. Two masks, one bit per channel, let the host find the channels that need service.

Top module: `mbx_ctrl`

## Requirements
- R1: After reset every slot reads IDLE. Both interrupt flags, the protocol error flag and both masks read 0.
- R2: The state encoding is IDLE=0, NEW=1, RCVD=2, COMPLETE=3. The state of channel c sits at bits [2c+1:2c] of `send_state_o` and of `recv_state_o`. A request with dir=0 addresses the send slot. A request with dir=1 addresses the receive slot. A request takes effect at the next clock edge.
- R3: Send slot handshake. The host posts (IDLE to NEW). The processor accepts (NEW to RCVD) and finishes (RCVD to COMPLETE). The host retires (COMPLETE to IDLE).
- R4: Receive slot handshake. The processor posts (IDLE to NEW). The host accepts (NEW to RCVD) and finishes (RCVD to COMPLETE). The processor retires (COMPLETE to IDLE).
- R5: Some requests are not permitted: a move by the wrong side, a skipped state, or a target equal to the current state. Such a request leaves the slot unchanged and sets `proto_err`.
- R6: A request whose channel number is 7 or above changes no slot and sets `proto_err`.
- R7: `proto_err` stays set until reset.
- R8: `int0` sets when any send slot enters COMPLETE. `int1` sets when any receive slot enters NEW. Both stay set afterwards.
- R9: `clr_int0` or `clr_int1` clears its flag at the next edge. If a qualifying entry happens in that same cycle, the flag stays set.
- R10: Bit c of `send_done_mask` is 1 exactly while send slot c is COMPLETE. Bit c of `recv_new_mask` is 1 exactly while receive slot c is NEW.
- R11: Requests from the two sides on different slots in the same cycle both take effect. If both sides address the same slot, only the permitted request applies and the other sets `proto_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_valid | input | 1 | Host state-change request |
| h_dir | input | 1 | Host target slot: 0 send, 1 receive |
| h_chan | input | 3 | Host channel number |
| h_state | input | 2 | Host requested state |
| p_valid | input | 1 | Processor state-change request |
| p_dir | input | 1 | Processor target slot: 0 send, 1 receive |
| p_chan | input | 3 | Processor channel number |
| p_state | input | 2 | Processor requested state |
| clr_int0 | input | 1 | Clear the send-complete flag |
| clr_int1 | input | 1 | Clear the receive-new flag |
| send_state_o | output | 14 | Send slot states, 2 bits per channel |
| recv_state_o | output | 14 | Receive slot states, 2 bits per channel |
| send_done_mask | output | 7 | Send slots in COMPLETE |
| recv_new_mask | output | 7 | Receive slots in NEW |
| int0 | output | 1 | Sticky send-complete flag |
| int1 | output | 1 | Sticky receive-new flag |
| proto_err | output | 1 | Sticky protocol error flag |

## Verification
Every slot state is a register driven straight to the ports. A wrong next-state choice therefore shows on `send_state_o` or `recv_state_o` one edge after the request. It shows as a slot that skipped a step, went backwards or held still. A missed error decision shows on `proto_err` in that same cycle. A lost or wrongly kept event shows on `int0` or `int1` one edge after the slot entered COMPLETE or NEW. It also shows one edge after a clear. Because the masks decode the states directly, an error in the masks is visible as soon as the state changes.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
    typedef enum logic [1:0] {
        MB_IDLE = 2'd0,
        MB_NEW  = 2'd1,
        MB_RCVD = 2'd2,
        MB_DONE = 2'd3
    } mb_state_e;
endpackage

// File: rtl/mbx_flag.sv
`timescale 1ns/1ps
// Sticky event flag; a set in the clearing cycle wins.
module mbx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) flag_o <= 1'b0;
        else        flag_o <= set_i | (flag_o & ~clr_i);
    end
endmodule

// File: rtl/mbx_slot.sv
`timescale 1ns/1ps
// One mailbox slot: owner posts and retires, responder accepts and finishes.
module mbx_slot
    import mbx_pkg::*;
#(
    parameter mb_state_e TRIG = MB_DONE   // state whose entry is reported
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      own_req,
    input  mb_state_e own_tgt,
    input  logic      rsp_req,
    input  mb_state_e rsp_tgt,
    output mb_state_e state_o,
    output logic      err_o,
    output logic      enter_o
);
    mb_state_e cur, nxt;
    logic      own_ok, rsp_ok;

    // next-state decision
    always_comb begin
        nxt    = cur;
        own_ok = 1'b0;
        rsp_ok = 1'b0;
        unique case (cur)
            MB_IDLE: own_ok = own_req && (own_tgt == MB_NEW);
            MB_NEW:  rsp_ok = rsp_req && (rsp_tgt == MB_RCVD);
            MB_RCVD: rsp_ok = rsp_req && (rsp_tgt == MB_DONE);
            MB_DONE: own_ok = own_req && (own_tgt == MB_IDLE);
        endcase
        if (own_ok)      nxt = own_tgt;
        else if (rsp_ok) nxt = rsp_tgt;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= MB_IDLE;
        else        cur <= nxt;
    end

    // outputs
    always_comb begin
        state_o = cur;
        err_o   = (own_req && !own_ok) || (rsp_req && !rsp_ok);
        enter_o = (nxt == TRIG) && (cur != TRIG);
    end
endmodule

// File: rtl/mbx_ctrl.sv
`timescale 1ns/1ps
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int NCH = 7,
    parameter int CW  = $clog2(NCH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            h_valid,
    input  logic            h_dir,
    input  logic [CW-1:0]   h_chan,
    input  logic [1:0]      h_state,
    input  logic            p_valid,
    input  logic            p_dir,
    input  logic [CW-1:0]   p_chan,
    input  logic [1:0]      p_state,
    input  logic            clr_int0,
    input  logic            clr_int1,
    output logic [2*NCH-1:0] send_state_o,
    output logic [2*NCH-1:0] recv_state_o,
    output logic [NCH-1:0]  send_done_mask,
    output logic [NCH-1:0]  recv_new_mask,
    output logic            int0,
    output logic            int1,
    output logic            proto_err
);
    localparam int SW = 2 * NCH;

    logic [NCH-1:0] s_err, r_err, s_enter, r_enter;
    logic           h_bad, p_bad, err_q;
    mb_state_e      h_tgt, p_tgt;

    assign h_tgt = mb_state_e'(h_state);
    assign p_tgt = mb_state_e'(p_state);
    assign h_bad = h_valid && (32'(h_chan) >= NCH);
    assign p_bad = p_valid && (32'(p_chan) >= NCH);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic      h_hit, p_hit;
        mb_state_e s_st, r_st;
        assign h_hit = h_valid && (h_chan == CW'(c));
        assign p_hit = p_valid && (p_chan == CW'(c));

        // send slot: host owns, processor responds
        mbx_slot #(.TRIG(MB_DONE)) u_send (
            .clk(clk), .rst_n(rst_n),
            .own_req(h_hit && !h_dir), .own_tgt(h_tgt),
            .rsp_req(p_hit && !p_dir), .rsp_tgt(p_tgt),
            .state_o(s_st), .err_o(s_err[c]), .enter_o(s_enter[c])
        );
        // receive slot: processor owns, host responds
        mbx_slot #(.TRIG(MB_NEW)) u_recv (
            .clk(clk), .rst_n(rst_n),
            .own_req(p_hit && p_dir), .own_tgt(p_tgt),
            .rsp_req(h_hit && h_dir), .rsp_tgt(h_tgt),
            .state_o(r_st), .err_o(r_err[c]), .enter_o(r_enter[c])
        );

        assign send_state_o[2*c +: 2] = s_st;
        assign recv_state_o[2*c +: 2] = r_st;
        assign send_done_mask[c]      = (s_st == MB_DONE);
        assign recv_new_mask[c]       = (r_st == MB_NEW);
    end

    mbx_flag u_int0 (.clk(clk), .rst_n(rst_n), .set_i(|s_enter), .clr_i(clr_int0), .flag_o(int0));
    mbx_flag u_int1 (.clk(clk), .rst_n(rst_n), .set_i(|r_enter), .clr_i(clr_int1), .flag_o(int1));

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_q | (|s_err) | (|r_err) | h_bad | p_bad;
    end
    assign proto_err = err_q;

    initial begin
        if (SW != $bits(send_state_o)) $error("state vector width");
    end
endmodule

// File: rtl/mbx_check.sv
`timescale 1ns/1ps
module mbx_check #(
    parameter int NCH = 7,
    parameter int CW  = $clog2(NCH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            h_valid,
    input logic [CW-1:0]   h_chan,
    input logic            p_valid,
    input logic [CW-1:0]   p_chan,
    input logic            clr_int0,
    input logic            clr_int1,
    input logic [2*NCH-1:0] send_state_o,
    input logic [2*NCH-1:0] recv_state_o,
    input logic [NCH-1:0]  send_done_mask,
    input logic [NCH-1:0]  recv_new_mask,
    input logic            int0,
    input logic            int1,
    input logic            proto_err
);
    for (genvar c = 0; c < NCH; c++) begin : g_ck
        // R3/R4: a slot only ever advances by one step around its cycle
        a_r3_send_step: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(send_state_o[2*c +: 2]) |->
                send_state_o[2*c +: 2] == $past(send_state_o[2*c +: 2]) + 2'd1);
        a_r4_recv_step: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(recv_state_o[2*c +: 2]) |->
                recv_state_o[2*c +: 2] == $past(recv_state_o[2*c +: 2]) + 2'd1);
    end

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    a_r6_bad_chan: assert property (@(posedge clk) disable iff (!rst_n)
        ((h_valid && 32'(h_chan) >= NCH) || (p_valid && 32'(p_chan) >= NCH)) |=> proto_err);

    a_r8_int0_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|(send_done_mask & ~$past(send_done_mask))) |-> int0);

    a_r8_int1_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|(recv_new_mask & ~$past(recv_new_mask))) |-> int1);

    a_r9_clr_int0: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_int0 && !h_valid && !p_valid) |=> !int0);

    a_r9_clr_int1: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_int1 && !h_valid && !p_valid) |=> !int1);
endmodule

bind mbx_ctrl mbx_check #(.NCH(NCH), .CW(CW)) u_chk (.*);

// File: tb/tb_mbx_ctrl.sv
`timescale 1ns/1ps
module tb_mbx_ctrl;
    localparam int NCH = 7;
    localparam logic [1:0] S_IDLE = 2'd0, S_NEW = 2'd1, S_RCVD = 2'd2, S_DONE = 2'd3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic h_valid = 0, h_dir = 0, p_valid = 0, p_dir = 0, clr_int0 = 0, clr_int1 = 0;
    logic [2:0] h_chan = 0, p_chan = 0;
    logic [1:0] h_state = 0, p_state = 0;
    logic [2*NCH-1:0] send_state_o, recv_state_o;
    logic [NCH-1:0] send_done_mask, recv_new_mask;
    logic int0, int1, proto_err;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    mbx_ctrl dut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // apply one cycle of requests; results are read 1 ns after the edge
    task automatic step(logic hv, logic hd, int hc, logic [1:0] hs,
                        logic pv, logic pd, int pc, logic [1:0] ps,
                        logic c0 = 0, logic c1 = 0);
        h_valid = hv; h_dir = hd; h_chan = 3'(hc); h_state = hs;
        p_valid = pv; p_dir = pd; p_chan = 3'(pc); p_state = ps;
        clr_int0 = c0; clr_int1 = c1;
        @(posedge clk); #1;
        h_valid = 0; p_valid = 0; clr_int0 = 0; clr_int1 = 0;
    endtask

    function automatic logic [1:0] sst(int c); return send_state_o[2*c +: 2]; endfunction
    function automatic logic [1:0] rst_(int c); return recv_state_o[2*c +: 2]; endfunction

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 send states", send_state_o, 0);
        check("R1 recv states", recv_state_o, 0);
        check("R1 flags", {int0, int1, proto_err}, 0);
        check("R1 masks", {send_done_mask, recv_new_mask}, 0);
    endtask

    task automatic t_send_flow();
        step(1, 0, 2, S_NEW, 0, 0, 0, 0);
        check("R3 post", sst(2), S_NEW);
        step(0, 0, 0, 0, 1, 0, 2, S_RCVD);
        check("R3 accept", sst(2), S_RCVD);
        check("R8 int0 not yet", int0, 0);
        step(0, 0, 0, 0, 1, 0, 2, S_DONE);
        check("R3 finish", sst(2), S_DONE);
        check("R8 int0 set", int0, 1);
        check("R10 send mask", send_done_mask, 7'b0000100);
        step(1, 0, 2, S_IDLE, 0, 0, 0, 0);
        check("R3 retire", sst(2), S_IDLE);
        check("R10 send mask cleared", send_done_mask, 0);
        check("R8 int0 sticky", int0, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        check("R9 int0 clear", int0, 0);
        check("R2 no error in legal flow", proto_err, 0);
    endtask

    task automatic t_recv_flow();
        step(0, 0, 0, 0, 1, 1, 6, S_NEW);
        check("R4 post", rst_(6), S_NEW);
        check("R8 int1 set", int1, 1);
        check("R10 recv mask", recv_new_mask, 7'b1000000);
        step(1, 1, 6, S_RCVD, 0, 0, 0, 0);
        check("R4 accept", rst_(6), S_RCVD);
        check("R10 recv mask off", recv_new_mask, 0);
        step(1, 1, 6, S_DONE, 0, 0, 0, 0);
        check("R4 finish", rst_(6), S_DONE);
        check("R8 int0 untouched by recv", int0, 0);
        step(0, 0, 0, 0, 1, 1, 6, S_IDLE);
        check("R4 retire", rst_(6), S_IDLE);
        check("R2 send side untouched", send_state_o, 0);
    endtask

    task automatic t_clear_race();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        check("R9 int1 clear", int1, 0);
        step(0, 0, 0, 0, 1, 1, 0, S_NEW, 0, 1);
        check("R9 set wins over clear", int1, 1);
        check("R4 post ch0", rst_(0), S_NEW);
    endtask

    task automatic t_parallel();
        step(1, 0, 3, S_NEW, 1, 1, 4, S_NEW);
        check("R11 host side", sst(3), S_NEW);
        check("R11 proc side", rst_(4), S_NEW);
        check("R11 no error", proto_err, 0);
    endtask

    task automatic t_illegal();
        do_reset();
        step(0, 0, 0, 0, 1, 0, 1, S_NEW);       // processor may not post a send
        check("R5 wrong side ignored", sst(1), S_IDLE);
        check("R5 error set", proto_err, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        check("R7 error sticky", proto_err, 1);
        step(1, 0, 1, S_RCVD, 0, 0, 0, 0);      // skipped state
        check("R5 skip ignored", sst(1), S_IDLE);
        do_reset();
        step(1, 0, 0, S_IDLE, 0, 0, 0, 0);      // target equals current
        check("R5 same state error", proto_err, 1);
        check("R5 same state no change", send_state_o, 0);
    endtask

    task automatic t_range();
        do_reset();
        step(1, 0, 7, S_NEW, 0, 0, 0, 0);
        check("R6 bad chan error", proto_err, 1);
        check("R6 no slot changed", {send_state_o, recv_state_o}, 0);
    endtask

    task automatic t_same_slot();
        do_reset();
        step(1, 0, 5, S_NEW, 1, 0, 5, S_RCVD);
        check("R11 permitted request applies", sst(5), S_NEW);
        check("R11 other request flagged", proto_err, 1);
    endtask

    initial begin
        t_reset();
        t_send_flow();
        t_recv_flow();
        t_clear_race();
        t_parallel();
        t_illegal();
        t_range();
        t_same_slot();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule